// File: doc/BRIEF.md
# Bus-Sizing Transfer Sequencer

This block sits on the master side of a chip-level I/O bus. A local client hands it one read or write of 1, 2, 4 or 8 bytes. The sequencer turns that request into one or more bus cycles. On every cycle the addressed slave answers with an acknowledge code that states how many bytes it actually moved. When the slave is narrower than the request, the sequencer issues follow-up cycles at once for the bytes still outstanding. It gathers read bytes into a single result and lines up write bytes for each follow-up cycle.

A slave that cannot serve a cycle yet can answer with a retry. The sequencer then steps off the bus for one cycle and presents the same cycle again. The number of retries allowed for each request is set by an input. An error acknowledge, an acknowledge wider than the cycle that was asked for, or running out of retries ends the request with an error response, and any partly gathered read data is dropped.

Any 8-byte cycle is preceded by one extended-information cycle. Arbitration, address translation and the electrical signalling are left to the surrounding logic.

Top module: `bus_sizing_seq`

## Requirements
- R1: After reset, and whenever no request is in flight, `reqReady` is 1 while `busSel`, `busExt` and `rspValid` are 0.
- R2: `reqSize` codes 0, 1, 2 and 3 request 1, 2, 4 and 8 bytes, and `reqAddr` is aligned to that size. A slave that acknowledges the full size completes the request in one bus cycle. The read result is right-justified in `rspRdata`, with the byte at the lowest address as the most significant byte.
- R3: `busAck` codes are: 0 wait, 1 one byte moved, 2 two bytes, 3 four bytes, 4 eight bytes, 5 retry, 6 error, 7 reserved (handled as error). While the code is 0, `busSel`, `busAddr` and `busSize` stay unchanged, and each wait cycle adds one cycle to the request.
- R4: Byte k of a bus cycle (k=0 is the byte at `busAddr`) travels on lane k. Lanes 0 to 3 are data bits 31:24, 23:16, 15:8 and 7:0. Lanes 4 to 7 are bits 63:56, 55:48, 47:40 and 39:32. A narrow acknowledge moves only the leading lanes, and the sequencer ignores the other lanes on reads.
- R5: After an acknowledge that moves fewer bytes than remain, the next cycle starts in the next clock with `busSel` still high. Its address is advanced by the bytes moved so far. Its `busSize` is the largest of 8, 4, 2 and 1 bytes that does not exceed the remaining count and to which the address is aligned.
- R6: Read bytes from all cycles are merged into the right position of one result. Write bytes reach the slave each exactly once, at the correct address.
- R7: Every cycle of `busSize` 3 is immediately preceded by exactly one cycle with `busExt` high and `busSel` low, and this includes re-issued cycles.
- R8: After a retry acknowledge, `busSel` goes low for one cycle and the same cycle, with the same address and size, is presented again.
- R9: Retries are counted per request. When the count reaches `retryLimit`, the request ends with an error response.
- R10: An error code, the reserved code, or a data acknowledge wider than the current `busSize` ends the request with `rspErr` high and `rspRdata` zero.
- R11: `rspValid` is a one-cycle pulse in the clock after the final acknowledge. `reqReady` is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqSize | input | 2 | Log2 of request byte count |
| reqAddr | input | ADDR_W | Byte address of request, size-aligned |
| reqWdata | input | 64 | Write value, right-justified |
| retryLimit | input | RETRY_W | Retry count that aborts a request |
| rspValid | output | 1 | Response pulse |
| rspErr | output | 1 | Response is an error |
| rspRdata | output | 64 | Read result, right-justified |
| busSel | output | 1 | Bus cycle active |
| busExt | output | 1 | Extended-information cycle before an 8-byte cycle |
| busAddr | output | ADDR_W | Current cycle byte address |
| busSize | output | 2 | Log2 of current cycle byte count |
| busWrite | output | 1 | Current cycle direction |
| busWdata | output | 64 | Write lanes |
| busRdata | input | 64 | Read lanes |
| busAck | input | 3 | Slave acknowledge code |

## Verification
The bench models slaves 1, 2, 4 and 8 bytes wide, with wait states and injected retries. It puts filler bytes on the lanes a narrow slave does not own, so a sequencer that does not mask lanes corrupts its read result. Counting data acknowledges exposes a wrong follow-up size or a missing follow-up cycle. A wrong address step shows up as misplaced bytes in the slave memory. A missing extended cycle before a re-issued 8-byte cycle shows up in the extended-cycle count. The retry limit is probed one below and exactly at the abort point, which catches an off-by-one compare. An error in the middle of a request checks that partial read bytes never leak into the response.

// File: rtl/bus_sizing_pkg.sv
package bus_sizing_pkg;
  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;

  localparam logic [2:0] ACK_WAIT  = 3'd0;
  localparam logic [2:0] ACK_B1    = 3'd1;
  localparam logic [2:0] ACK_B8    = 3'd4;
  localparam logic [2:0] ACK_RETRY = 3'd5;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic load;    // capture a new request
    logic commit;  // accept the bytes of the current data acknowledge
    logic drop;    // discard gathered read bytes
  } seqStrobe_t;

  function automatic logic ackIsData(input logic [2:0] a);
    return (a >= ACK_B1) && (a <= ACK_B8);
  endfunction
endpackage

// File: rtl/bus_sizing_dp.sv
module bus_sizing_dp
  import bus_sizing_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [2:0]        busAck,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              lastMove,
  output logic              tooWide
);
  localparam int CNT_W = $clog2(LANES) + 1;
  localparam int SH_W  = $clog2(DATA_W) + 1;
  localparam int HALF  = DATA_W / 2;

  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        totLog;
  logic [CNT_W-1:0]  doneCnt;
  logic              wrFlag;
  logic [DATA_W-1:0] wBuf;
  logic [DATA_W-1:0] asmBuf;

  logic [CNT_W-1:0]  totBytes, remBytes, moved, newTot;
  logic [1:0]        ackLog, curLog;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] laneOut, laneIn, keepMask;

  always_comb begin
    totBytes = CNT_W'(1) << totLog;
    remBytes = totBytes - doneCnt;
    curAddr  = baseAddr + ADDR_W'(doneCnt);
    // largest aligned power of two that fits in what is left
    curLog = 2'd0;
    for (int k = 1; k < 4; k++) begin
      if (remBytes >= (CNT_W'(1) << k) && (curAddr[2:0] & 3'((1 << k) - 1)) == 3'b000)
        curLog = 2'(k);
    end
    ackLog   = 2'(busAck - 3'd1);
    moved    = CNT_W'(1) << ackLog;
    lastMove = moved >= remBytes;
    tooWide  = ackLog > curLog;
    newTot   = CNT_W'(1) << reqSize;
    // lane-ordered vectors: lane 0 in the top byte
    laneOut  = wBuf << {doneCnt, 3'b000};
    laneIn   = {busRdata[HALF-1:0], busRdata[DATA_W-1:HALF]};
    keepMask = ~({DATA_W{1'b1}} >> {moved, 3'b000});
  end

  assign busAddr  = curAddr;
  assign busSize  = curLog;
  assign busWrite = wrFlag;
  assign busWdata = {laneOut[HALF-1:0], laneOut[DATA_W-1:HALF]};
  assign rspRdata = asmBuf >> (SH_W'(DATA_W) - {totBytes, 3'b000});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      totLog   <= '0;
      doneCnt  <= '0;
      wrFlag   <= 1'b0;
      wBuf     <= '0;
      asmBuf   <= '0;
    end else if (strobe.load) begin
      baseAddr <= reqAddr;
      totLog   <= reqSize;
      doneCnt  <= '0;
      wrFlag   <= reqWrite;
      wBuf     <= reqWdata << (SH_W'(DATA_W) - {newTot, 3'b000});
      asmBuf   <= '0;
    end else begin
      if (strobe.commit) begin
        doneCnt <= doneCnt + moved;
        asmBuf  <= asmBuf | ((laneIn & keepMask) >> {doneCnt, 3'b000});
      end
      if (strobe.drop) asmBuf <= '0;
    end
  end
endmodule

// File: rtl/bus_sizing_ctrl.sv
module bus_sizing_ctrl
  import bus_sizing_pkg::*;
#(
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqSize,
  input  logic [2:0]         busAck,
  input  logic [1:0]         busSize,
  input  logic               lastMove,
  input  logic               tooWide,
  input  logic [RETRY_W-1:0] retryLimit,
  output seqStrobe_t         strobe,
  output logic               reqReady,
  output logic               busSel,
  output logic               busExt,
  output logic               rspValid,
  output logic               rspErr
);
  typedef enum logic [1:0] {S_IDLE, S_EXT, S_BUSY, S_GAP} seqState_e;

  seqState_e          state, stNext;
  logic [RETRY_W-1:0] retryCnt;
  logic [RETRY_W:0]   retryNext;
  logic               finOk, finErr, bumpRetry;

  assign retryNext = {1'b0, retryCnt} + 1'b1;

  always_comb begin
    strobe    = '0;
    stNext    = state;
    finOk     = 1'b0;
    finErr    = 1'b0;
    bumpRetry = 1'b0;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        stNext = (reqSize == 2'd3) ? S_EXT : S_BUSY;
      end
      S_EXT: stNext = S_BUSY;
      S_BUSY: begin
        if (ackIsData(busAck)) begin
          if (tooWide) finErr = 1'b1;
          else begin
            strobe.commit = 1'b1;
            finOk = lastMove;
          end
        end else if (busAck == ACK_RETRY) begin
          if (retryNext >= {1'b0, retryLimit}) finErr = 1'b1;
          else begin
            bumpRetry = 1'b1;
            stNext = S_GAP;
          end
        end else if (busAck != ACK_WAIT) begin
          finErr = 1'b1;
        end
        if (finOk || finErr) stNext = S_IDLE;
        strobe.drop = finErr;
      end
      S_GAP: stNext = (busSize == 2'd3) ? S_EXT : S_BUSY;
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      retryCnt <= '0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      state    <= stNext;
      rspValid <= finOk | finErr;
      rspErr   <= finErr;
      if (strobe.load) retryCnt <= '0;
      else if (bumpRetry) retryCnt <= retryNext[RETRY_W-1:0];
    end
  end

  assign reqReady = (state == S_IDLE);
  assign busSel   = (state == S_BUSY);
  assign busExt   = (state == S_EXT);
endmodule

// File: rtl/bus_sizing_seq.sv
module bus_sizing_seq
  import bus_sizing_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWrite,
  input  logic [1:0]         reqSize,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [63:0]        reqWdata,
  input  logic [RETRY_W-1:0] retryLimit,
  output logic               rspValid,
  output logic               rspErr,
  output logic [63:0]        rspRdata,
  output logic               busSel,
  output logic               busExt,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [1:0]         busSize,
  output logic               busWrite,
  output logic [63:0]        busWdata,
  input  logic [63:0]        busRdata,
  input  logic [2:0]         busAck
);
  seqStrobe_t strobe;
  logic       lastMove, tooWide;

  bus_sizing_ctrl #(.RETRY_W(RETRY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSize(reqSize),
    .busAck(busAck), .busSize(busSize), .lastMove(lastMove), .tooWide(tooWide),
    .retryLimit(retryLimit), .strobe(strobe), .reqReady(reqReady),
    .busSel(busSel), .busExt(busExt), .rspValid(rspValid), .rspErr(rspErr)
  );

  bus_sizing_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busAck(busAck), .busRdata(busRdata), .busAddr(busAddr),
    .busSize(busSize), .busWrite(busWrite), .busWdata(busWdata),
    .rspRdata(rspRdata), .lastMove(lastMove), .tooWide(tooWide)
  );
endmodule

// File: rtl/bus_sizing_seq_chk.sv
module bus_sizing_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspErr,
  input logic [63:0]       rspRdata,
  input logic              busSel,
  input logic              busExt,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        busSize,
  input logic [2:0]        busAck
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busSel && !busExt)); // R1

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAck == 3'd0) |=> (busSel && $stable(busAddr) && $stable(busSize))); // R3

  AST_CYCLE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    busSel |-> ((busAddr[2:0] & ((3'd1 << busSize) - 3'd1)) == 3'd0)); // R5

  AST_EXT_LEADS_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !$past(busSel) && busSize == 2'd3) |-> $past(busExt)); // R7

  AST_RETRY_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAck == 3'd5) |=> !busSel); // R8

  AST_REISSUE_SAME: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && $past(busSel, 2) && $past(busAck, 2) == 3'd5) |-> (busAddr == $past(busAddr, 2))); // R8

  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspRdata == 64'd0)); // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R11
endmodule

bind bus_sizing_seq bus_sizing_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .rspErr(rspErr), .rspRdata(rspRdata), .busSel(busSel), .busExt(busExt),
  .busAddr(busAddr), .busSize(busSize), .busAck(busAck)
);

// File: tb/bus_sizing_seq_tb.sv
module bus_sizing_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqReady;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [63:0] reqWdata = '0;
  logic [3:0]  retryLimit = 4'd3;
  logic        rspValid, rspErr;
  logic [63:0] rspRdata;
  logic        busSel, busExt, busWrite;
  logic [31:0] busAddr;
  logic [1:0]  busSize;
  logic [63:0] busWdata, busRdata;
  logic [2:0]  busAck;

  bus_sizing_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .retryLimit(retryLimit), .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .busSel(busSel), .busExt(busExt), .busAddr(busAddr), .busSize(busSize),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck)
  );

  // ---------------- slave model ----------------
  logic [1:0] portLog = 2'd3, waitSt = 2'd0;
  int         retryTarget = 0, errAfter = -1;
  logic       wideInj = 1'b0;
  logic [7:0] mem [16];
  int         waitCnt, retryUsed, dataAcks, extCnt;
  logic [1:0] effLog;
  logic [63:0] rdLanes, wrLanes;

  always_comb begin
    effLog = (portLog < busSize) ? portLog : busSize;
    busAck = 3'd0;
    if (busSel && waitCnt == int'(waitSt)) begin
      if (errAfter >= 0 && dataAcks == errAfter) busAck = 3'd6;
      else if (wideInj) busAck = 3'd4;
      else if (retryUsed < retryTarget) busAck = 3'd5;
      else busAck = {1'b0, effLog} + 3'd1;
    end
    for (int i = 0; i < 8; i++)
      rdLanes[63-8*i -: 8] = (i < (1 << effLog)) ? mem[4'(busAddr[3:0] + i)] : 8'hEE;
    busRdata = {rdLanes[31:0], rdLanes[63:32]};
    wrLanes  = {busWdata[31:0], busWdata[63:32]};
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'(8'h30 + i * 7);
      waitCnt <= 0; retryUsed <= 0; dataAcks <= 0; extCnt <= 0;
    end else if (reqValid) begin
      waitCnt <= 0; retryUsed <= 0; dataAcks <= 0; extCnt <= 0;
    end else begin
      if (busAck != 3'd0 || !busSel) waitCnt <= 0;
      else waitCnt <= waitCnt + 1;
      if (busAck == 3'd5) retryUsed <= retryUsed + 1;
      if (busAck >= 3'd1 && busAck <= 3'd4) begin
        dataAcks <= dataAcks + 1;
        if (busWrite)
          for (int i = 0; i < 8; i++)
            if (i < (1 << (busAck - 3'd1))) mem[4'(busAddr[3:0] + i)] <= wrLanes[63-8*i -: 8];
      end
      if (busExt) extCnt <= extCnt + 1;
    end
  end

  // ---------------- checking ----------------
  int nChecks = 0, nFail = 0, lastLat = 0;

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic runOp(input logic wr, input logic [1:0] lg, input logic [3:0] ad,
                       input logic [63:0] wd, input logic [1:0] pl, input logic [1:0] ws,
                       input int rt, input int ea, input logic wi, input logic expErr);
    logic [7:0]  snap [16];
    logic [63:0] expRd, gotRd;
    logic        gotErr, memOk;
    int n, lat, cyc, mn;
    n = 1 << lg;
    for (int i = 0; i < 16; i++) snap[i] = mem[i];
    portLog = pl; waitSt = ws; retryTarget = rt; errAfter = ea; wideInj = wi;
    reqWrite = wr; reqSize = lg; reqAddr = {28'h0, ad}; reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!rspValid && lat < 400) begin @(negedge clk); lat++; end
    if (!rspValid) begin
      chk(1'b0, "R11", "no response", 64'd0, 64'd1);
      return;
    end
    lastLat = lat;
    gotErr = rspErr; gotRd = rspRdata;
    chk(reqReady, "R11", "ready beside response", {63'd0, reqReady}, 64'd1);
    @(negedge clk);
    chk(!rspValid, "R11", "response pulse width", {63'd0, rspValid}, 64'd0);
    if (expErr) begin
      chk(gotErr, "R9 R10", "error flag", {63'd0, gotErr}, 64'd1);
      if (!wr) chk(gotRd == 64'd0, "R10", "dropped read data", gotRd, 64'd0);
    end else begin
      chk(!gotErr, "R2", "error flag", {63'd0, gotErr}, 64'd0);
      if (!wr) begin
        expRd = '0;
        for (int i = 0; i < n; i++) expRd = (expRd << 8) | {56'd0, snap[4'(ad + i)]};
        chk(gotRd == expRd, "R4 R6", "read data", gotRd, expRd);
      end else begin
        for (int i = 0; i < n; i++) snap[4'(ad + i)] = wd[8*(n-1-i) +: 8];
        memOk = 1'b1;
        for (int i = 0; i < 16; i++) if (mem[i] !== snap[i]) memOk = 1'b0;
        chk(memOk, "R4 R6", "slave memory after write", {63'd0, memOk}, 64'd1);
      end
      mn  = (pl < lg) ? int'(pl) : int'(lg);
      cyc = 1 << (int'(lg) - mn);
      chk(dataAcks == cyc, "R2 R5", "data cycles", 64'(dataAcks), 64'(cyc));
      chk(extCnt == ((lg == 2'd3) ? 1 + rt : 0), "R7", "extended cycles",
          64'(extCnt), 64'((lg == 2'd3) ? 1 + rt : 0));
      if (rt > 0) chk(retryUsed == rt, "R8", "retries absorbed", 64'(retryUsed), 64'(rt));
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  lg;
    logic [3:0]  ad;
    logic [63:0] wd;
    logic [1:0]  pl;
    logic [1:0]  ws;
    logic [1:0]  rt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd3, 4'd0,  64'd0,                  2'd3, 2'd0, 2'd0},
    '{1'b0, 2'd3, 4'd8,  64'd0,                  2'd0, 2'd1, 2'd0},
    '{1'b1, 2'd3, 4'd0,  64'h1122334455667788,   2'd1, 2'd0, 2'd0},
    '{1'b0, 2'd3, 4'd0,  64'd0,                  2'd2, 2'd0, 2'd1},
    '{1'b1, 2'd2, 4'd4,  64'h00000000CAFEF00D,   2'd0, 2'd2, 2'd1},
    '{1'b0, 2'd2, 4'd4,  64'd0,                  2'd1, 2'd0, 2'd0},
    '{1'b1, 2'd1, 4'd14, 64'h000000000000BEEF,   2'd3, 2'd0, 2'd2},
    '{1'b0, 2'd1, 4'd14, 64'd0,                  2'd0, 2'd0, 2'd0},
    '{1'b1, 2'd0, 4'd3,  64'h000000000000005A,   2'd2, 2'd0, 2'd0},
    '{1'b0, 2'd0, 4'd3,  64'd0,                  2'd0, 2'd3, 2'd0},
    '{1'b0, 2'd2, 4'd12, 64'd0,                  2'd3, 2'd1, 2'd2}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 idle state after reset
    chk(reqReady && !busSel && !busExt && !rspValid, "R1", "idle after reset",
        {60'd0, reqReady, busSel, busExt, rspValid}, 64'h8);

    for (int v = 0; v < NV; v++)
      runOp(VECS[v].wr, VECS[v].lg, VECS[v].ad, VECS[v].wd, VECS[v].pl, VECS[v].ws,
            int'(VECS[v].rt), -1, 1'b0, 1'b0);

    // R3 wait states lengthen the single cycle
    runOp(1'b0, 2'd2, 4'd4, 64'd0, 2'd2, 2'd3, 0, -1, 1'b0, 1'b0);
    chk(lastLat == 4, "R3", "latency with three waits", 64'(lastLat), 64'd4);

    // R9 limit reached aborts, one more allowed passes
    retryLimit = 4'd3;
    runOp(1'b0, 2'd1, 4'd2, 64'd0, 2'd3, 2'd0, 3, -1, 1'b0, 1'b1);
    retryLimit = 4'd4;
    runOp(1'b0, 2'd1, 4'd2, 64'd0, 2'd3, 2'd0, 3, -1, 1'b0, 1'b0);
    retryLimit = 4'd3;

    // R10 error after partial bytes, and over-wide acknowledge
    runOp(1'b0, 2'd3, 4'd0, 64'd0, 2'd0, 2'd0, 0, 3, 1'b0, 1'b1);
    runOp(1'b0, 2'd0, 4'd5, 64'd0, 2'd3, 2'd0, 0, -1, 1'b1, 1'b1);

    // R1 quiet again after an aborted request
    chk(reqReady && !busSel && !busExt, "R1", "idle after error",
        {61'd0, reqReady, busSel, busExt}, 64'h4);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule